// File: doc/BRIEF.md
# Flit token deserializer

This block takes in a stream of 16-bit flits on a valid/ready input. It reads a prefix code at the top of each header flit to find the packet length, which is one flit or two. When the packet has a second word, the block collects it as data. For every packet it presents one decoded token on a registered output, and the token stays there until the consumer accepts it.

Five kinds of token come out of the block:

- A memory-unit request.
- A two-operand (dyadic) token.
- A single-operand (monadic) token that carries data.
- A single-flit inline token that carries no data.
- A raw two-word packet, used for frame control or a local write. The block does not interpret its contents.

Fields that do not belong to a kind are driven to zero. The header word is also presented unchanged next to the decoded fields.

The block sits between a network ejection port and the consumers of tokens. Its control is a two-state machine: it waits for a header, then waits for data. A synchronous reset drops any packet that is only partly received.

Top module: `flit_token_deser`

## Requirements
- R1: After a synchronous reset, `tok_valid` is 0 and `in_ready` is 1. Any packet that was partly received is discarded, so the next accepted flit is treated as a header.
- R2: A header with bit 15 = 1 starts a two-flit packet with kind code 3. The fields are: unit = bits 14:13, memop = bits 12:10, addr = bits 9:0, data = the second flit.
- R3: A header with bits 15:14 = 00 starts a two-flit packet with kind code 0. The fields are: port = bit 13, unit = bits 12:11, offset = bits 10:3, act = bits 2:0, data = the second flit.
- R4: A header with bits 15:13 = 010 starts a two-flit packet with kind code 1. Port is 0 and data is the second flit; unit, offset and act are taken from the same bits as in R3.
- R5: A header with bits 15:13 = 011 and bits 10:9 = 10 is a one-flit packet with kind code 2. The fields are: unit = bits 12:11, offset = bits 8:2 zero-extended to 8 bits, act = 0, data = 0.
- R6: A header with bits 15:13 = 011 and bits 10:9 not equal to 10 starts a two-flit packet with kind code 4. Data is the second flit, and unit, port, offset, act, memop and addr are all 0.
- R7: For every kind, `tok_hdr` equals the header flit of the packet.
- R8: Every field that is not named for a kind in R2 to R6 is 0.
- R9: While `tok_valid` is 1 and `tok_ready` is 0, all token outputs keep their value and `in_ready` is 0, so no flit is consumed.
- R10: `in_ready` is 1 whenever no token is held, or whenever the held token is accepted in that same cycle. The token appears on the outputs in the cycle after its last flit is accepted, so a steady input yields one inline token per cycle.
- R11: A flit is consumed only in a cycle where `in_valid` and `in_ready` are both 1. Idle cycles between a header and its data change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | Block can take a flit |
| in_flit | input | 16 | Input flit |
| tok_valid | output | 1 | Decoded token held |
| tok_ready | input | 1 | Consumer takes the token |
| tok_kind | output | 3 | Kind: 0 dyadic, 1 monadic, 2 inline, 3 memory, 4 raw |
| tok_unit | output | 2 | Target PE or memory unit |
| tok_port | output | 1 | Operand port |
| tok_offset | output | 8 | Frame offset |
| tok_act | output | 3 | Activation id |
| tok_memop | output | 3 | Memory operation |
| tok_addr | output | 10 | Memory address |
| tok_data | output | 16 | Data word (second flit) |
| tok_hdr | output | 16 | Header flit as received |

## Verification
Two events can fall in the same clock edge: the consumer accepting the held token, and the block accepting the next flit, which may complete another token. The bench provokes this by holding `tok_ready` high while it streams inline headers and two-flit packets back to back with no gaps. After every edge it requires `in_ready` to be 1 and the outputs to show the newest token, with every field checked against the arithmetic model. The opposite case is also covered: with `tok_ready` held low, a flit offered on the input must be refused and the token outputs must not move.

// File: rtl/tokdes_pkg.sv
package tokdes_pkg;
  localparam int FLIT_W    = 16;
  localparam int UNIT_W    = 2;
  localparam int OFF_W     = 8;
  localparam int INL_OFF_W = OFF_W - 1;
  localparam int ACT_W     = 3;
  localparam int OP_W      = 3;
  localparam int ADDR_W    = 10;
  localparam int KIND_W    = 3;

  typedef enum logic [KIND_W-1:0] {
    TK_DYAD   = 3'd0,
    TK_MONO   = 3'd1,
    TK_INLINE = 3'd2,
    TK_MEM    = 3'd3,
    TK_RAW    = 3'd4
  } tok_kind_e;

  typedef enum logic {
    ST_HDR  = 1'b0,
    ST_DATA = 1'b1
  } rx_state_e;

  typedef struct packed {
    tok_kind_e             kind;
    logic [UNIT_W-1:0]     unit;
    logic                  port;
    logic [OFF_W-1:0]      offset;
    logic [ACT_W-1:0]      act;
    logic [OP_W-1:0]       memop;
    logic [ADDR_W-1:0]     addr;
    logic [FLIT_W-1:0]     data;
    logic [FLIT_W-1:0]     hdr;
  } tok_t;
endpackage

// File: rtl/tokdes_classify.sv
module tokdes_classify
  import tokdes_pkg::*;
(
  input  logic [FLIT_W-1:0] hdr,
  input  logic [FLIT_W-1:0] data_in,
  output tok_t              tok,
  output logic              single
);
  localparam int TOP = FLIT_W - 1;

  always_comb begin
    tok     = '0;
    tok.hdr = hdr;
    single  = 1'b0;
    if (hdr[TOP]) begin
      tok.kind  = TK_MEM;
      tok.unit  = hdr[TOP-1 -: UNIT_W];
      tok.memop = hdr[TOP-1-UNIT_W -: OP_W];
      tok.addr  = hdr[ADDR_W-1:0];
      tok.data  = data_in;
    end else if (!hdr[TOP-1]) begin
      tok.kind   = TK_DYAD;
      tok.port   = hdr[TOP-2];
      tok.unit   = hdr[TOP-3 -: UNIT_W];
      tok.offset = hdr[ACT_W +: OFF_W];
      tok.act    = hdr[ACT_W-1:0];
      tok.data   = data_in;
    end else if (!hdr[TOP-2]) begin
      tok.kind   = TK_MONO;
      tok.unit   = hdr[TOP-3 -: UNIT_W];
      tok.offset = hdr[ACT_W +: OFF_W];
      tok.act    = hdr[ACT_W-1:0];
      tok.data   = data_in;
    end else if (hdr[TOP-5 -: 2] == 2'b10) begin
      tok.kind   = TK_INLINE;
      tok.unit   = hdr[TOP-3 -: UNIT_W];
      tok.offset = {1'b0, hdr[2 +: INL_OFF_W]};
      single     = 1'b1;
    end else begin
      tok.kind = TK_RAW;
      tok.data = data_in;
    end
  end
endmodule

// File: rtl/tokdes_ctrl.sv
module tokdes_ctrl
  import tokdes_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_flit,
  input  logic              out_free,
  input  logic              single,
  output logic              in_ready,
  output logic [FLIT_W-1:0] hdr_sel,
  output logic [FLIT_W-1:0] data_sel,
  output logic              load
);
  rx_state_e         st;
  logic [FLIT_W-1:0] hdr_q;
  logic              fire;

  assign in_ready = out_free;
  assign fire     = in_valid & in_ready;
  assign hdr_sel  = (st == ST_DATA) ? hdr_q : in_flit;
  assign data_sel = (st == ST_DATA) ? in_flit : '0;
  assign load     = fire & ((st == ST_DATA) | single);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_HDR;
      hdr_q <= '0;
    end else if (fire) begin
      if (st == ST_HDR) begin
        if (!single) begin
          st    <= ST_DATA;
          hdr_q <= in_flit;
        end
      end else begin
        st <= ST_HDR;
      end
    end
  end

  // R3
  hdr_to_data_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HDR && fire && !single) |=> (st == ST_DATA && hdr_q == $past(in_flit)));
  // R11
  stall_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA && !fire) |=> (st == ST_DATA && $stable(hdr_q)));
  // R5
  inline_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HDR && fire && single) |=> (st == ST_HDR));
  // R1
  ctrl_reset_chk: assert property (@(posedge clk)
    rst |=> (st == ST_HDR));
endmodule

// File: rtl/tokdes_outreg.sv
module tokdes_outreg
  import tokdes_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  tok_t tok_in,
  input  logic tok_ready,
  output logic tok_valid,
  output tok_t tok_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tok_valid <= 1'b0;
      tok_q     <= '0;
    end else if (load) begin
      tok_valid <= 1'b1;
      tok_q     <= tok_in;
    end else if (tok_ready) begin
      tok_valid <= 1'b0;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && !tok_ready) |=> (tok_valid && $stable(tok_q)));
  // R10
  no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> (!tok_valid || tok_ready));
  // R10
  appear_next_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> tok_valid);
  // R1
  out_reset_chk: assert property (@(posedge clk)
    rst |=> !tok_valid);
endmodule

// File: rtl/flit_token_deser.sv
module flit_token_deser
  import tokdes_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [FLIT_W-1:0]    in_flit,
  output logic                 tok_valid,
  input  logic                 tok_ready,
  output logic [KIND_W-1:0]    tok_kind,
  output logic [UNIT_W-1:0]    tok_unit,
  output logic                 tok_port,
  output logic [OFF_W-1:0]     tok_offset,
  output logic [ACT_W-1:0]     tok_act,
  output logic [OP_W-1:0]      tok_memop,
  output logic [ADDR_W-1:0]    tok_addr,
  output logic [FLIT_W-1:0]    tok_data,
  output logic [FLIT_W-1:0]    tok_hdr
);
  logic              out_free;
  logic              single;
  logic              load;
  logic [FLIT_W-1:0] hdr_sel;
  logic [FLIT_W-1:0] data_sel;
  tok_t              tok_dec;
  tok_t              tok_q;

  assign out_free = ~tok_valid | tok_ready;

  tokdes_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_flit  (in_flit),
    .out_free (out_free),
    .single   (single),
    .in_ready (in_ready),
    .hdr_sel  (hdr_sel),
    .data_sel (data_sel),
    .load     (load)
  );

  tokdes_classify u_cls (
    .hdr     (hdr_sel),
    .data_in (data_sel),
    .tok     (tok_dec),
    .single  (single)
  );

  tokdes_outreg u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .tok_in    (tok_dec),
    .tok_ready (tok_ready),
    .tok_valid (tok_valid),
    .tok_q     (tok_q)
  );

  assign tok_kind   = tok_q.kind;
  assign tok_unit   = tok_q.unit;
  assign tok_port   = tok_q.port;
  assign tok_offset = tok_q.offset;
  assign tok_act    = tok_q.act;
  assign tok_memop  = tok_q.memop;
  assign tok_addr   = tok_q.addr;
  assign tok_data   = tok_q.data;
  assign tok_hdr    = tok_q.hdr;

  // R6
  raw_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_kind == TK_RAW) |->
      (tok_unit == '0 && !tok_port && tok_offset == '0 && tok_act == '0 &&
       tok_memop == '0 && tok_addr == '0));
  // R5
  inline_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_kind == TK_INLINE) |-> (tok_data == '0 && tok_act == '0));
  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && !tok_ready) |-> !in_ready);
endmodule

// File: tb/flit_token_deser_tb.sv
module flit_token_deser_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 0;
  logic        rst = 1;
  logic        in_valid = 0;
  logic        in_ready;
  logic [15:0] in_flit = '0;
  logic        tok_valid;
  logic        tok_ready = 0;
  logic [2:0]  tok_kind;
  logic [1:0]  tok_unit;
  logic        tok_port;
  logic [7:0]  tok_offset;
  logic [2:0]  tok_act;
  logic [2:0]  tok_memop;
  logic [9:0]  tok_addr;
  logic [15:0] tok_data;
  logic [15:0] tok_hdr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  logic [31:0] lcg = 32'h1234_5678;

  flit_token_deser u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_kind(tok_kind), .tok_unit(tok_unit),
    .tok_port(tok_port), .tok_offset(tok_offset), .tok_act(tok_act), .tok_memop(tok_memop),
    .tok_addr(tok_addr), .tok_data(tok_data), .tok_hdr(tok_hdr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [61:0] model(input logic [15:0] h, input logic [15:0] d);
    int hv, k, u, p, o, a, m, ad, dd;
    hv = h; k = 0; u = 0; p = 0; o = 0; a = 0; m = 0; ad = 0; dd = 0;
    if (hv >= 32768) begin
      k = 3; u = (hv / 8192) % 4; m = (hv / 1024) % 8; ad = hv % 1024; dd = d;
    end else if (hv / 16384 == 0) begin
      k = 0; p = (hv / 8192) % 2; u = (hv / 2048) % 4; o = (hv / 8) % 256; a = hv % 8; dd = d;
    end else if (hv / 8192 == 2) begin
      k = 1; u = (hv / 2048) % 4; o = (hv / 8) % 256; a = hv % 8; dd = d;
    end else if ((hv / 512) % 4 == 2) begin
      k = 2; u = (hv / 2048) % 4; o = (hv / 4) % 128;
    end else begin
      k = 4; dd = d;
    end
    return {k[2:0], u[1:0], p[0], o[7:0], a[2:0], m[2:0], ad[9:0], dd[15:0], h};
  endfunction

  function automatic logic [61:0] actual();
    return {tok_kind, tok_unit, tok_port, tok_offset, tok_act, tok_memop, tok_addr, tok_data, tok_hdr};
  endfunction

  function automatic string kind_tag(input logic [15:0] h);
    logic [61:0] e;
    e = model(h, 16'h0);
    case (e[61:59])
      3'd0: return "R3 R7 R8";
      3'd1: return "R4 R7 R8";
      3'd2: return "R5 R7 R8";
      3'd3: return "R2 R7 R8";
      default: return "R6 R7 R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] f);
    in_valid = 1;
    in_flit  = f;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    in_flit  = 16'hDEAD;
  endtask

  task automatic accept();
    tok_ready = 1;
    @(negedge clk);
    tok_ready = 0;
  endtask

  function automatic logic [15:0] next_rand();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[30:15];
  endfunction

  initial begin
    logic [15:0] h, d;
    logic [61:0] held;
    bit two;

    // R1 reset state
    repeat (3) @(negedge clk);
    rst = 0;
    check(tok_valid == 0 && in_ready == 1, "R1", {62'd0, tok_valid, in_ready}, 64'd1);

    // sweep of header classes
    for (int i = 0; i < 512; i++) begin
      h = next_rand();
      d = next_rand();
      case (i % 8)
        0: h[15] = 1'b1;
        1: h[15:14] = 2'b00;
        2: h[15:13] = 3'b010;
        3, 4, 5, 6: begin h[15:13] = 3'b011; h[10:9] = 2'(i % 8 - 3); end
        default: ;
      endcase
      two = !(h[15:13] == 3'b011 && h[10:9] == 2'b10);
      send(h);
      if (two) begin
        if (i % 3 == 0) begin
          in_flit = next_rand();
          @(negedge clk);
          in_flit = next_rand();
          @(negedge clk);
          check(tok_valid == 0, "R11 idle gap", {63'd0, tok_valid}, 64'd0);
        end
        send(d);
      end
      check(tok_valid == 1 && actual() == model(h, d), kind_tag(h),
            {1'b0, tok_valid, actual()}, {2'b01, model(h, d)});
      if (i % 4 == 0) begin
        held = actual();
        in_valid = 1;
        in_flit = next_rand();
        @(negedge clk);
        @(negedge clk);
        check(in_ready == 0 && tok_valid == 1 && actual() == held, "R9 hold",
              {1'b0, in_ready, actual()}, {2'b00, held});
        in_valid = 0;
      end
      accept();
      check(tok_valid == 0, "R9 release", {63'd0, tok_valid}, 64'd0);
    end

    // R1 reset in the middle of a packet
    send(16'h1234);
    rst = 1;
    @(negedge clk);
    rst = 0;
    send(16'h6444);
    check(tok_valid == 1 && actual() == model(16'h6444, 16'h0), "R1 mid-packet",
          {2'b0, actual()}, {2'b0, model(16'h6444, 16'h0)});
    rst = 1;
    @(negedge clk);
    rst = 0;
    check(tok_valid == 0 && in_ready == 1, "R1 drop held", {62'd0, tok_valid, in_ready}, 64'd1);

    // R10 inline stream, acceptance and intake in the same cycle
    tok_ready = 1;
    for (int j = 0; j < 16; j++) begin
      h = 16'h6400 | 16'(j << 2) | 16'((j % 4) << 11);
      in_valid = 1;
      in_flit = h;
      @(negedge clk);
      check(in_ready == 1 && tok_valid == 1 && actual() == model(h, 16'h0), "R10 stream",
            {1'b0, in_ready, actual()}, {2'b01, model(h, 16'h0)});
    end
    in_valid = 0;
    @(negedge clk);
    check(tok_valid == 0, "R10 drain", {63'd0, tok_valid}, 64'd0);

    // R10 two-flit stream with no gaps
    for (int j = 0; j < 8; j++) begin
      h = next_rand();
      d = next_rand();
      if (j % 2 == 0) h[15:14] = 2'b00; else h[15] = 1'b1;
      in_valid = 1;
      in_flit = h;
      @(negedge clk);
      in_flit = d;
      @(negedge clk);
      check(in_ready == 1 && tok_valid == 1 && actual() == model(h, d), "R10 pair stream",
            {1'b0, in_ready, actual()}, {2'b01, model(h, d)});
    end
    in_valid = 0;
    @(negedge clk);
    tok_ready = 0;

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule